// File: doc/BRIEF.md
# Idle-Triggered Deep Power-Down Controller

This block sequences power-down for an Ethernet transceiver. It watches two inputs: a link-present indication from the receive side and the transmit-enable input from the MAC. The line is idle when the link is absent and transmit-enable is low. The controller counts consecutive idle cycles of the reference clock. When the count reaches a fixed window, the block enters a deep power-down state. At the default 25 MHz reference, that window is 800,000,000 cycles, which is 32 seconds.

In deep power-down the block drives four separate shutdown outputs: one each for the transmit PLL, the receive and equalizer path, the transmit DAC and clock-data recovery. Each output is enabled by its own bit of a five-bit control field that management logic writes. The transmit DAC line driver has an output enable, and that enable is withdrawn whenever the DAC is shut down, so the line floats. As soon as the link returns or transmit-enable rises, every shutdown output clears in the same cycle. The sequencer then goes back to the active state and starts a fresh window.

Top module: `dpd_sequencer`

## Requirements
- R1: While `rst` is high, and after it is released, `pm_state` reads 2'b00 (active), all four shutdown outputs are low, `dac_oe` is high and `cfg_rdata` reads the reset value 5'b01111.
- R2: A cycle is idle only when `link_up` is low and `tx_en` is low. The first idle cycle sampled in the active state moves `pm_state` to 2'b01 (counting).
- R3: `pm_state` becomes 2'b10 (powered-down) at the clock edge that samples the IDLE_CYCLES-th consecutive idle cycle. Until then it reads 2'b01.
- R4: A non-idle cycle sampled while counting returns `pm_state` to 2'b00. A later idle run must then last a full IDLE_CYCLES cycles before power-down.
- R5: While powered-down and idle, each shutdown output equals its control bit: bit 3 for `pll_pd`, bit 2 for `rx_pd`, bit 1 for `dac_pd` and bit 0 for `cdr_pd`. In any other state all four are low.
- R6: `dac_oe` is the inverse of `dac_pd`, so the DAC line output is released whenever the DAC is shut down.
- R7: While powered-down, a high `link_up` or `tx_en` clears all shutdown outputs in the same cycle, without waiting for a clock edge. `pm_state` reads 2'b00 after the next edge.
- R8: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored and appears on `cfg_rdata`. Bit 4 is stored but drives no shutdown output.
- R9: A control write made while powered-down changes the shutdown outputs from the following cycle onward. Control writes never count as line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link partner signal present |
| tx_en | input | 1 | MAC transmit enable |
| cfg_we | input | 1 | Control field write strobe |
| cfg_wdata | input | 5 | Control field write data |
| cfg_rdata | output | 5 | Stored control field |
| pll_pd | output | 1 | Transmit PLL shutdown |
| rx_pd | output | 1 | Receive/equalizer shutdown |
| dac_pd | output | 1 | Transmit DAC shutdown |
| cdr_pd | output | 1 | Clock-data recovery shutdown |
| dac_oe | output | 1 | DAC line output enable (low means high impedance) |
| pm_state | output | 2 | 00 active, 01 counting, 10 powered-down |

## Verification
The case that is hardest to reach from the ports is a restart one cycle short of the window: a counting run that is broken at cycle IDLE_CYCLES-1 and then has to run a full window again. The bench uses a short window. It holds idle for one cycle less than the window, injects a single active cycle, and then shows that a further IDLE_CYCLES-1 idle cycles still read as counting. Waking without a clock edge is checked by raising `link_up` between edges while powered-down and sampling the shutdown outputs before the next edge.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
   typedef enum logic [1:0] {
      PM_ACTIVE = 2'b00,
      PM_COUNT  = 2'b01,
      PM_DOWN   = 2'b10
   } pm_state_e;

   localparam int CFG_W   = 5;
   localparam int DOM_N   = 4;
   localparam int DOM_CDR = 0;
   localparam int DOM_DAC = 1;
   localparam int DOM_RX  = 2;
   localparam int DOM_PLL = 3;
endpackage

// File: rtl/dpd_idle_timer.sv
module dpd_idle_timer
   import dpd_pkg::*;
#(
   parameter int unsigned IDLE_CYCLES = 800_000_000
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      idle,
   output pm_state_e state_q
);
   localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

   if (IDLE_CYCLES < 2) begin : g_bad_window
      $error("IDLE_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PM_ACTIVE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            PM_ACTIVE: begin
               if (idle) begin
                  state_q <= PM_COUNT;
                  cnt_q   <= CNT_W'(1);
               end
            end
            PM_COUNT: begin
               if (!idle) begin
                  state_q <= PM_ACTIVE;
                  cnt_q   <= '0;
               end else if (cnt_q == LAST) begin
                  state_q <= PM_DOWN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PM_DOWN: begin
               if (!idle) state_q <= PM_ACTIVE;
            end
            default: begin
               state_q <= PM_ACTIVE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   // R3
   down_entry_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(state_q == PM_DOWN) |-> ($past(state_q) == PM_COUNT && $past(idle)));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(cnt_q) < IDLE_CYCLES));

   // R4
   cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == PM_COUNT && !idle) |=> (state_q == PM_ACTIVE && cnt_q == '0));
endmodule

// File: rtl/dpd_cfg_reg.sv
module dpd_cfg_reg #(
   parameter int            W         = 5,
   parameter logic [W-1:0]  RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= RESET_VAL;
      else if (we) q <= wdata;
   end

   // R8
   cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (q == $past(wdata)));
endmodule

// File: rtl/dpd_domain_gate.sv
module dpd_domain_gate #(
   parameter int N = 4
) (
   input  logic         in_down,
   input  logic         idle,
   input  logic [N-1:0] mask,
   output logic [N-1:0] pd
);
   for (genvar i = 0; i < N; i++) begin : g_dom
      assign pd[i] = in_down & idle & mask[i];
   end

   // R7
   always_comb begin
      wake_clear_chk: assert (idle || pd == '0);
   end
endmodule

// File: rtl/dpd_sequencer.sv
module dpd_sequencer
   import dpd_pkg::*;
#(
   parameter int unsigned        IDLE_CYCLES = 800_000_000,
   parameter logic [CFG_W-1:0]   CFG_RESET   = 5'b01111
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             link_up,
   input  logic             tx_en,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             pll_pd,
   output logic             rx_pd,
   output logic             dac_pd,
   output logic             cdr_pd,
   output logic             dac_oe,
   output logic [1:0]       pm_state
);
   logic            idle;
   pm_state_e       state;
   logic [DOM_N-1:0] pd;

   assign idle = !link_up && !tx_en;

   dpd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
      .clk(clk), .rst(rst), .idle(idle), .state_q(state)
   );

   dpd_cfg_reg #(.W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
      .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
   );

   dpd_domain_gate #(.N(DOM_N)) u_gate (
      .in_down(state == PM_DOWN), .idle(idle),
      .mask(cfg_rdata[DOM_N-1:0]), .pd(pd)
   );

   assign pll_pd   = pd[DOM_PLL];
   assign rx_pd    = pd[DOM_RX];
   assign dac_pd   = pd[DOM_DAC];
   assign cdr_pd   = pd[DOM_CDR];
   assign dac_oe   = ~pd[DOM_DAC];
   assign pm_state = state;

   // R5
   no_pd_outside_chk: assert property (@(posedge clk) disable iff (rst)
      (pm_state != 2'b10) |-> !(pll_pd || rx_pd || dac_pd || cdr_pd));

   // R6
   dac_hiz_chk: assert property (@(posedge clk) disable iff (rst)
      dac_pd |-> !dac_oe);
endmodule

// File: tb/tb_dpd_sequencer.sv
module tb_dpd_sequencer;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic link_up = 1'b0, tx_en = 1'b0, cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic [4:0] cfg_rdata;
   logic pll_pd, rx_pd, dac_pd, cdr_pd, dac_oe;
   logic [1:0] pm_state;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   dpd_sequencer #(.IDLE_CYCLES(N), .CFG_RESET(5'b01111)) dut (
      .clk(clk), .rst(rst), .link_up(link_up), .tx_en(tx_en),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pll_pd(pll_pd), .rx_pd(rx_pd), .dac_pd(dac_pd), .cdr_pd(cdr_pd),
      .dac_oe(dac_oe), .pm_state(pm_state)
   );

   // vector: link, tx, cycles, expected state, expected {pll,rx,dac,cdr}
   typedef struct packed {
      logic       lk;
      logic       tx;
      logic [7:0] cyc;
      logic [1:0] st;
      logic [3:0] pd;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{1'b1, 1'b0, 8'd3, 2'b00, 4'b0000},
      '{1'b0, 1'b0, 8'd7, 2'b01, 4'b0000},
      '{1'b0, 1'b1, 8'd1, 2'b00, 4'b0000},
      '{1'b0, 1'b0, 8'd7, 2'b01, 4'b0000},
      '{1'b0, 1'b0, 8'd1, 2'b10, 4'b1111},
      '{1'b0, 1'b0, 8'd5, 2'b10, 4'b1111},
      '{1'b1, 1'b0, 8'd1, 2'b00, 4'b0000},
      '{1'b0, 1'b0, 8'd8, 2'b10, 4'b1111},
      '{1'b0, 1'b1, 8'd2, 2'b00, 4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] pdv();
      return {pll_pd, rx_pd, dac_pd, cdr_pd};
   endfunction

   task automatic hold(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      hold(2);
      // R1 during reset
      chk("R1 state in reset", 32'(pm_state), 32'h0);
      chk("R1 pd in reset", 32'(pdv()), 32'h0);
      chk("R1 dac_oe in reset", 32'(dac_oe), 32'h1);
      chk("R1 cfg reset value", 32'(cfg_rdata), 32'h0F);
      link_up = 1'b1;
      rst = 1'b0;
      hold(1);
      chk("R1 state after reset", 32'(pm_state), 32'h0);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < 9; i++) begin
         link_up = VECS[i].lk;
         tx_en   = VECS[i].tx;
         hold(int'(VECS[i].cyc));
         chk($sformatf("R3/R4 state vec%0d", i), 32'(pm_state), 32'(VECS[i].st));
         chk($sformatf("R5 pd vec%0d", i), 32'(pdv()), 32'(VECS[i].pd));
         chk($sformatf("R6 dac_oe vec%0d", i), 32'(dac_oe), 32'(!VECS[i].pd[1]));
      end

      // R2 first idle cycle gives counting
      tx_en = 1'b0; link_up = 1'b0;
      hold(1);
      chk("R2 counting after one idle", 32'(pm_state), 32'h1);
      hold(N - 1);
      chk("R3 down after window", 32'(pm_state), 32'h2);

      // R7 same-cycle wake
      link_up = 1'b1;
      #1;
      chk("R7 pd clear before edge", 32'(pdv()), 32'h0);
      chk("R7 dac_oe before edge", 32'(dac_oe), 32'h1);
      chk("R7 state still down", 32'(pm_state), 32'h2);
      hold(1);
      chk("R7 active after edge", 32'(pm_state), 32'h0);

      // R8 write with bit 4 and rx only
      cfg_we = 1'b1; cfg_wdata = 5'b10100;
      hold(1);
      cfg_we = 1'b0;
      chk("R8 readback", 32'(cfg_rdata), 32'h14);
      link_up = 1'b0;
      hold(N);
      chk("R8 down reached", 32'(pm_state), 32'h2);
      chk("R8 bit4 drives nothing", 32'(pdv()), 32'b0100);
      chk("R8 dac_oe kept", 32'(dac_oe), 32'h1);

      // R9 write while down
      cfg_we = 1'b1; cfg_wdata = 5'b01011;
      #1;
      chk("R9 old mask before edge", 32'(pdv()), 32'b0100);
      hold(1);
      cfg_we = 1'b0;
      chk("R9 new mask", 32'(pdv()), 32'b1011);
      chk("R9 write not activity", 32'(pm_state), 32'h2);
      chk("R6 dac off hiz", 32'(dac_oe), 32'h0);

      // R5 zero mask while down
      cfg_we = 1'b1; cfg_wdata = 5'b00000;
      hold(1);
      cfg_we = 1'b0;
      chk("R5 zero mask no pd", 32'(pdv()), 32'h0);
      chk("R5 still down", 32'(pm_state), 32'h2);

      // R1 reset from powered-down
      cfg_we = 1'b1; cfg_wdata = 5'b01111;
      hold(1);
      cfg_we = 1'b0;
      rst = 1'b1;
      hold(1);
      chk("R1 reset from down state", 32'(pm_state), 32'h0);
      chk("R1 reset from down pd", 32'(pdv()), 32'h0);
      rst = 1'b0;
      cfg_we = 1'b1; cfg_wdata = 5'b00001;
      hold(1);
      cfg_we = 1'b0;
      rst = 1'b1;
      hold(1);
      chk("R1 reset restores cfg", 32'(cfg_rdata), 32'h0F);
      rst = 1'b0;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule